// File: doc/BRIEF.md
# Fault Injection Campaign Controller

This block runs a campaign of emulated upsets against a small target design. The target's state registers form one flat vector. Two copies of the target run side by side: a reference copy that is never disturbed and a faulty copy that receives the bit inversions. Every run follows the same steps. The controller draws a target bit and an injection cycle from a pseudo-random generator and resets both copies. It runs the workload, inverts the chosen bit or bits of the faulty copy at the injection cycle, and compares the primary outputs of the two copies on every later cycle. The run ends at the first output disagreement or at the final cycle. The controller then emits one result record, and the reset that opens the next run repairs the fault.

The target included here is a stand-in with three register regions. The low bits form an output counter, where an upset becomes a visible failure on the next cycle. The middle bits hold their value and are never seen at the outputs, so an upset there stays latent. The top bits are scratch bits that are cleared every cycle, so an upset there is masked unless the run ends immediately after the injection. Software loads a seed, a run count, a final cycle and a flip model, pulses start, and drains records through a valid/ready stream.

Top module: `fic_campaign`

## Requirements
- R1: After reset, and whenever reset is asserted mid-campaign, busy, done and rec_valid are all low.
- R2: A start pulse in idle latches cfg_seed, cfg_runs, cfg_tf and cfg_multi, and busy goes high on the next cycle. A start pulse while busy is ignored, and later changes on the cfg inputs have no effect on the campaign in progress.
- R3: The generator is a 32-bit shift register. Its next value is {s[30:0], s[31]^s[21]^s[1]^s[0]}, and a seed of 0 is replaced by 1. Each run advances it twice, giving v1 and then v2. The target bit is v1 mod NREG. Ti is v2 mod Tf, and a result of 0 becomes 1. A cfg_tf below 2 is treated as 2.
- R4: Cycle 0 of a run is the reset cycle. The fault is applied at the clock edge that ends cycle Ti. Outputs are compared on every cycle after Ti, up to and including Tf. For a failure, rec_fail_cyc is the first cycle in which the outputs differ, which is Ti+1 for this target. For any other outcome it is 0.
- R5: When cfg_multi=0, exactly one bit is inverted. When cfg_multi=1, GRP bits are inverted in the same cycle, at indices target, target+1, and so on, wrapping from NREG-1 back to 0.
- R6: The outcome code is 1 (failure) if the outputs ever differ. It is 2 (latent) if the outputs never differ but the register vectors differ at Tf. Otherwise it is 0 (silent). Bits [OUTW-1:0] feed the outputs. Bits [NREG-SCRW-1:OUTW] hold their value. Bits [NREG-1:NREG-SCRW] are cleared each cycle.
- R7: A scratch bit inverted at Ti = Tf-1 is still set at Tf, so the run is classified latent.
- R8: Each record carries the run number, counting from 0, the target bit, the model, Ti, the outcome and the failure cycle.
- R9: While rec_valid is high and rec_ready is low, the record stays valid and every field holds its value.
- R10: Done is high for exactly one cycle, starting in the cycle after the last record is accepted. A run count of 0 gives that done pulse in the cycle after start, with no records.
- R11: Every run begins from a fresh reset of both copies, so a fault left in place by an earlier run does not affect later runs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Campaign start strobe |
| cfg_seed | input | 32 | Generator seed |
| cfg_runs | input | RUNW | Number of runs |
| cfg_tf | input | CYCW | Final cycle Tf of each run |
| cfg_multi | input | 1 | 0 = single bit, 1 = adjacent group |
| busy | output | 1 | Campaign in progress |
| done | output | 1 | One-cycle campaign completion pulse |
| rec_valid | output | 1 | Record available |
| rec_ready | input | 1 | Record accepted when high with rec_valid |
| rec_run | output | RUNW | Run number |
| rec_bit | output | IDXW | First inverted bit index |
| rec_multi | output | 1 | Flip model used |
| rec_ti | output | CYCW | Injection cycle |
| rec_outcome | output | 2 | 0 silent, 1 failure, 2 latent |
| rec_fail_cyc | output | CYCW | Cycle of first output mismatch, else 0 |

## Verification
The bench builds the block with NREG=12, which is not a power of two, so the modulo reduction of the target index is non-trivial. It also uses OUTW=3, SCRW=3 and GRP=3, so groups that start at bits 10 or 11 wrap into the output region. Tf values of 1, 2 and 3 make Ti = Tf-1 frequent, which brings the masked-scratch-turned-latent corner within reach. A final cycle of 40 gives long runs where scratch upsets are masked.

// File: rtl/fic_pkg.sv
`timescale 1ns/1ps
package fic_pkg;

  typedef enum logic [2:0] {
    PH_IDLE, PH_DRAW, PH_RST, PH_RUN, PH_REC, PH_FIN
  } phase_t;

  localparam logic [1:0] OC_SILENT = 2'd0;
  localparam logic [1:0] OC_FAIL   = 2'd1;
  localparam logic [1:0] OC_LATENT = 2'd2;

  localparam logic [31:0] GEN_TAPS = 32'h8020_0003;

  // one step of the 32-bit maximal-length shift generator
  function automatic logic [31:0] gen_step(input logic [31:0] s);
    return {s[30:0], ^(s & GEN_TAPS)};
  endfunction

endpackage

// File: rtl/fic_lfsr_draw.sv
`timescale 1ns/1ps
module fic_lfsr_draw
  import fic_pkg::*;
#(
  parameter int NREG = 16,
  parameter int CYCW = 12,
  localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            load,
  input  logic [31:0]     seed,
  input  logic            step,
  input  logic [CYCW-1:0] tf,
  output logic [IDXW-1:0] tgt_o,
  output logic [CYCW-1:0] ti_o
);

  logic [31:0]     gen_q;
  logic [31:0]     v1, v2;
  logic [IDXW-1:0] tgt_q;
  logic [CYCW-1:0] ti_q;

  function automatic logic [IDXW-1:0] to_index(input logic [31:0] v);
    logic [31:0] m;
    m = v % 32'(NREG);
    return m[IDXW-1:0];
  endfunction

  function automatic logic [CYCW-1:0] to_ti(input logic [31:0] v, input logic [CYCW-1:0] lim);
    logic [31:0] m;
    m = v % 32'(lim);
    if (m == 32'd0) m = 32'd1;
    return m[CYCW-1:0];
  endfunction

  assign v1 = gen_step(gen_q);
  assign v2 = gen_step(v1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gen_q <= 32'd1;
      tgt_q <= '0;
      ti_q  <= CYCW'(1);
    end else if (load) begin
      gen_q <= (seed == 32'd0) ? 32'd1 : seed;
    end else if (step) begin
      gen_q <= v2;
      tgt_q <= to_index(v1);
      ti_q  <= to_ti(v2, tf);
    end
  end

  assign tgt_o = tgt_q;
  assign ti_o  = ti_q;

  AST_TI_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (ti_o >= CYCW'(1)) && (ti_o < $past(tf)));  // R3
  AST_TGT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    step |=> (32'(tgt_o) < 32'(NREG)));  // R3
  AST_GEN_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    gen_q != 32'd0);  // R3

endmodule

// File: rtl/fic_mask.sv
`timescale 1ns/1ps
module fic_mask #(
  parameter int NREG = 16,
  parameter int GRP  = 2,
  localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic [IDXW-1:0] tgt,
  input  logic            multi,
  output logic [NREG-1:0] mask
);

  localparam logic [NREG-1:0] ONE = {{(NREG-1){1'b0}}, 1'b1};

  // index tgt+off, wrapped back into 0..NREG-1
  function automatic logic [IDXW-1:0] wrap_add(input logic [IDXW-1:0] t, input int off);
    logic [IDXW:0] s;
    logic [31:0]   o;
    o = 32'(off);
    s = {1'b0, t} + o[IDXW:0];
    if (32'(s) >= 32'(NREG)) s = s - (IDXW+1)'(NREG);
    return s[IDXW-1:0];
  endfunction

  logic [NREG-1:0] part [GRP];

  for (genvar g = 0; g < GRP; g++) begin : g_member
    if (g == 0) begin : g_lead
      assign part[g] = ONE << wrap_add(tgt, g);
    end else begin : g_follow
      assign part[g] = multi ? (ONE << wrap_add(tgt, g)) : '0;
    end
  end

  always_comb begin
    mask = '0;
    for (int k = 0; k < GRP; k++) mask = mask | part[k];
  end

endmodule

// File: rtl/fic_target.sv
`timescale 1ns/1ps
module fic_target #(
  parameter int NREG = 16,
  parameter int OUTW = 4,
  parameter int SCRW = 4,
  localparam int SCR_LO = NREG - SCRW
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            clr,
  input  logic            en,
  input  logic [NREG-1:0] flip,
  output logic [NREG-1:0] state_o,
  output logic [OUTW-1:0] out_o
);

  localparam logic [OUTW-1:0] INC = {{(OUTW-1){1'b0}}, 1'b1};

  logic [NREG-1:0] st_q, nxt;

  // low region counts, middle region holds, scratch region clears
  always_comb begin
    nxt = st_q;
    if (en) begin
      nxt[OUTW-1:0]      = st_q[OUTW-1:0] + INC;
      nxt[NREG-1:SCR_LO] = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   st_q <= '0;
    else if (clr) st_q <= '0;
    else          st_q <= nxt ^ flip;
  end

  assign state_o = st_q;
  assign out_o   = st_q[OUTW-1:0];

endmodule

// File: rtl/fic_campaign.sv
`timescale 1ns/1ps
module fic_campaign
  import fic_pkg::*;
#(
  parameter int NREG = 16,
  parameter int OUTW = 4,
  parameter int SCRW = 4,
  parameter int GRP  = 2,
  parameter int RUNW = 8,
  parameter int CYCW = 12,
  localparam int IDXW = (NREG > 1) ? $clog2(NREG) : 1
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [31:0]     cfg_seed,
  input  logic [RUNW-1:0] cfg_runs,
  input  logic [CYCW-1:0] cfg_tf,
  input  logic            cfg_multi,
  output logic            busy,
  output logic            done,
  output logic            rec_valid,
  input  logic            rec_ready,
  output logic [RUNW-1:0] rec_run,
  output logic [IDXW-1:0] rec_bit,
  output logic            rec_multi,
  output logic [CYCW-1:0] rec_ti,
  output logic [1:0]      rec_outcome,
  output logic [CYCW-1:0] rec_fail_cyc
);

  localparam logic [CYCW-1:0] TF_MIN = CYCW'(2);

  phase_t          ph_q;
  logic [RUNW-1:0] runs_q, run_q;
  logic [CYCW-1:0] tf_q, cyc_q, failcyc_q;
  logic            multi_q;
  logic [1:0]      outcome_q;

  logic [IDXW-1:0] tgt;
  logic [CYCW-1:0] ti;
  logic [NREG-1:0] mask, flip;
  logic [NREG-1:0] gold_st, bad_st;
  logic [OUTW-1:0] gold_out, bad_out;

  // named internal events
  logic start_evt, inject_evt, mismatch_evt, horizon_evt, accept_evt, last_run;
  logic out_diff, st_diff, in_run;

  function automatic logic [CYCW-1:0] clamp_tf(input logic [CYCW-1:0] t);
    return (t < TF_MIN) ? TF_MIN : t;
  endfunction

  function automatic logic [1:0] end_class(input logic state_differs);
    return state_differs ? OC_LATENT : OC_SILENT;
  endfunction

  assign in_run       = (ph_q == PH_RUN);
  assign start_evt    = start && (ph_q == PH_IDLE);
  assign out_diff     = (gold_out != bad_out);
  assign st_diff      = (gold_st != bad_st);
  assign inject_evt   = in_run && (cyc_q == ti);
  assign mismatch_evt = in_run && (cyc_q > ti) && out_diff;
  assign horizon_evt  = in_run && !mismatch_evt && (cyc_q == tf_q);
  assign accept_evt   = rec_valid && rec_ready;
  assign last_run     = (run_q == runs_q - RUNW'(1));
  assign flip         = inject_evt ? mask : '0;

  fic_lfsr_draw #(.NREG(NREG), .CYCW(CYCW)) u_draw (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (start_evt),
    .seed  (cfg_seed),
    .step  (ph_q == PH_DRAW),
    .tf    (tf_q),
    .tgt_o (tgt),
    .ti_o  (ti)
  );

  fic_mask #(.NREG(NREG), .GRP(GRP)) u_mask (
    .tgt   (tgt),
    .multi (multi_q),
    .mask  (mask)
  );

  fic_target #(.NREG(NREG), .OUTW(OUTW), .SCRW(SCRW)) u_gold (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (ph_q == PH_RST),
    .en      (in_run),
    .flip    ('0),
    .state_o (gold_st),
    .out_o   (gold_out)
  );

  fic_target #(.NREG(NREG), .OUTW(OUTW), .SCRW(SCRW)) u_bad (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (ph_q == PH_RST),
    .en      (in_run),
    .flip    (flip),
    .state_o (bad_st),
    .out_o   (bad_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q      <= PH_IDLE;
      runs_q    <= '0;
      run_q     <= '0;
      tf_q      <= TF_MIN;
      multi_q   <= 1'b0;
      cyc_q     <= '0;
      outcome_q <= OC_SILENT;
      failcyc_q <= '0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (start_evt) begin
          runs_q  <= cfg_runs;
          tf_q    <= clamp_tf(cfg_tf);
          multi_q <= cfg_multi;
          run_q   <= '0;
          ph_q    <= (cfg_runs == '0) ? PH_FIN : PH_DRAW;
        end
        PH_DRAW: begin
          cyc_q <= '0;
          ph_q  <= PH_RST;
        end
        PH_RST: begin
          cyc_q <= CYCW'(1);
          ph_q  <= PH_RUN;
        end
        PH_RUN: begin
          if (mismatch_evt) begin
            outcome_q <= OC_FAIL;
            failcyc_q <= cyc_q;
            ph_q      <= PH_REC;
          end else if (horizon_evt) begin
            outcome_q <= end_class(st_diff);
            failcyc_q <= '0;
            ph_q      <= PH_REC;
          end else begin
            cyc_q <= cyc_q + CYCW'(1);
          end
        end
        PH_REC: if (accept_evt) begin
          if (last_run) begin
            ph_q <= PH_FIN;
          end else begin
            run_q <= run_q + RUNW'(1);
            ph_q  <= PH_DRAW;
          end
        end
        PH_FIN:  ph_q <= PH_IDLE;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  assign busy         = (ph_q != PH_IDLE);
  assign done         = (ph_q == PH_FIN);
  assign rec_valid    = (ph_q == PH_REC);
  assign rec_run      = run_q;
  assign rec_bit      = tgt;
  assign rec_multi    = multi_q;
  assign rec_ti       = ti;
  assign rec_outcome  = outcome_q;
  assign rec_fail_cyc = failcyc_q;

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R10
  AST_REC_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && !rec_ready) |=> rec_valid && $stable(rec_run) && $stable(rec_bit)
      && $stable(rec_ti) && $stable(rec_outcome) && $stable(rec_fail_cyc));  // R9
  AST_CFG_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (start && busy) |=> $stable(runs_q) && $stable(tf_q) && $stable(multi_q));  // R2
  AST_FLIP_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    inject_evt |-> ($countones(bad_st ^ gold_st) == 0)
      && ($countones(flip) == (multi_q ? GRP : 1)));  // R5
  AST_FRESH_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    (in_run && cyc_q == CYCW'(1)) |-> !st_diff && !out_diff);  // R11
  AST_FAIL_AFTER_TI: assert property (@(posedge clk) disable iff (!rst_n)
    (rec_valid && rec_outcome == OC_FAIL) |-> (rec_fail_cyc > rec_ti) && (rec_fail_cyc <= tf_q));  // R4
  AST_OUTCOME_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    rec_valid |-> (rec_outcome != 2'd3));  // R6

endmodule

// File: tb/sim_fic_campaign.sv
`timescale 1ns/1ps
module sim_fic_campaign;

  localparam int NREG = 12;
  localparam int OUTW = 3;
  localparam int SCRW = 3;
  localparam int GRP  = 3;
  localparam int RUNW = 8;
  localparam int CYCW = 10;
  localparam int IDXW = $clog2(NREG);

  // seed[52:21] runs[20:13] tf[12:3] multi[2] stall[1:0]
  localparam int NVEC = 6;
  localparam logic [52:0] VEC [NVEC] = '{
    {32'h0000_0001, 8'd6,  10'd8,  1'b0, 2'd0},
    {32'h0000_ACE1, 8'd8,  10'd3,  1'b1, 2'd1},
    {32'h0000_0000, 8'd5,  10'd2,  1'b0, 2'd0},
    {32'hDEAD_BEEF, 8'd10, 10'd40, 1'b1, 2'd2},
    {32'h1234_5678, 8'd12, 10'd5,  1'b0, 2'd0},
    {32'h0BAD_F00D, 8'd9,  10'd1,  1'b1, 2'd0}
  };

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [31:0]     cfg_seed = '0;
  logic [RUNW-1:0] cfg_runs = '0;
  logic [CYCW-1:0] cfg_tf = '0;
  logic            cfg_multi = 1'b0;
  logic            rec_ready = 1'b0;
  logic            busy, done, rec_valid, rec_multi;
  logic [RUNW-1:0] rec_run;
  logic [IDXW-1:0] rec_bit;
  logic [CYCW-1:0] rec_ti, rec_fail_cyc;
  logic [1:0]      rec_outcome;

  int errs = 0;
  int checks = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  fic_campaign #(.NREG(NREG), .OUTW(OUTW), .SCRW(SCRW), .GRP(GRP),
                 .RUNW(RUNW), .CYCW(CYCW)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .cfg_seed(cfg_seed),
    .cfg_runs(cfg_runs), .cfg_tf(cfg_tf), .cfg_multi(cfg_multi),
    .busy(busy), .done(done), .rec_valid(rec_valid), .rec_ready(rec_ready),
    .rec_run(rec_run), .rec_bit(rec_bit), .rec_multi(rec_multi),
    .rec_ti(rec_ti), .rec_outcome(rec_outcome), .rec_fail_cyc(rec_fail_cyc)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // generator restated with explicit tap bits
  function automatic logic [31:0] adv(input logic [31:0] s);
    logic fb;
    fb = s[31] ^ s[21] ^ s[1] ^ s[0];
    return {s[30:0], fb};
  endfunction

  // expected outcome from the region map of R6, corner of R7
  task automatic predict(input int tgt, input bit multi, input int ti, input int tf,
                         output int oc, output int fc, output bit corner);
    bit in_out, in_mid, in_scr;
    in_out = 0; in_mid = 0; in_scr = 0;
    for (int k = 0; k < (multi ? GRP : 1); k++) begin
      int b;
      b = (tgt + k) % NREG;
      if (b < OUTW) in_out = 1;
      else if (b >= NREG - SCRW) in_scr = 1;
      else in_mid = 1;
    end
    corner = 0;
    if (in_out) begin oc = 1; fc = ti + 1; end
    else if (in_mid) begin oc = 2; fc = 0; end
    else if (in_scr && ti == tf - 1) begin oc = 2; fc = 0; corner = 1; end
    else begin oc = 0; fc = 0; end
  endtask

  task automatic run_camp(input logic [31:0] seed, input int runs, input int tf,
                          input bit multi, input int stall, input bit ghost);
    logic [31:0] s, v1, v2;
    int tfe, tgt, ti, oc, fc;
    bit corner;
    string tag;
    @(negedge clk);
    cfg_seed = seed; cfg_runs = RUNW'(runs); cfg_tf = CYCW'(tf); cfg_multi = multi;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    cfg_seed = ~seed; cfg_runs = RUNW'(runs + 3); cfg_tf = CYCW'(tf + 7); cfg_multi = ~multi;
    if (runs == 0) begin
      chk(done == 1'b1, "R10", "done after zero-run start", done, 1);
      chk(rec_valid == 1'b0, "R10", "no record for zero runs", rec_valid, 0);
      @(negedge clk);
      chk(done == 1'b0 && busy == 1'b0, "R10", "done one cycle only", done, 0);
      return;
    end
    chk(busy == 1'b1, "R2", "busy after start", busy, 1);
    if (ghost) begin
      @(negedge clk);
      cfg_runs = RUNW'(1); cfg_seed = 32'h7777_0000;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    s = (seed == 32'd0) ? 32'd1 : seed;
    tfe = (tf < 2) ? 2 : tf;
    for (int r = 0; r < runs; r++) begin
      v1 = adv(s); v2 = adv(v1); s = v2;
      tgt = int'(v1 % 32'(NREG));
      ti  = int'(v2 % 32'(tfe));
      if (ti == 0) ti = 1;
      predict(tgt, multi, ti, tfe, oc, fc, corner);
      while (!rec_valid) @(negedge clk);
      chk(int'(rec_run) == r, ghost ? "R2" : "R8", "run number", rec_run, r);
      chk(int'(rec_bit) == tgt, "R3", "target bit", rec_bit, tgt);
      chk(int'(rec_ti) == ti, "R3", "injection cycle", rec_ti, ti);
      chk(rec_multi == multi, "R8", "model field", rec_multi, multi);
      if (corner) tag = "R7";
      else if (multi) tag = "R5";
      else if (r > 0) tag = "R11";
      else tag = "R6";
      chk(int'(rec_outcome) == oc, tag, "outcome", rec_outcome, oc);
      chk(int'(rec_fail_cyc) == fc, "R4", "failure cycle", rec_fail_cyc, fc);
      for (int k = 0; k < stall; k++) begin
        @(negedge clk);
        chk(rec_valid && int'(rec_outcome) == oc && int'(rec_ti) == ti
            && int'(rec_bit) == tgt && int'(rec_run) == r && int'(rec_fail_cyc) == fc,
            "R9", "record held under stall", rec_valid, 1);
      end
      rec_ready = 1'b1;
      @(negedge clk);
      rec_ready = 1'b0;
      if (r == runs - 1) begin
        chk(done == 1'b1, "R10", "done after last accept", done, 1);
        @(negedge clk);
        chk(done == 1'b0 && busy == 1'b0, "R10", "done pulse width", done, 0);
      end else begin
        chk(done == 1'b0, "R10", "no done mid campaign", done, 0);
      end
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && rec_valid == 1'b0, "R1", "reset outputs",
        {busy, done, rec_valid}, 0);
    rst_n = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      run_camp(VEC[i][52:21], int'(VEC[i][20:13]), int'(VEC[i][12:3]),
               VEC[i][2], int'(VEC[i][1:0]), 1'b0);
    end

    // zero-run campaign
    run_camp(32'h0000_0042, 0, 6, 1'b0, 0, 1'b0);
    // start while busy is ignored
    run_camp(32'h0000_5EED, 3, 6, 1'b1, 0, 1'b1);

    // reset in the middle of a campaign
    @(negedge clk);
    cfg_seed = 32'h0000_0099; cfg_runs = RUNW'(4); cfg_tf = CYCW'(30); cfg_multi = 1'b0;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    repeat (5) @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0 && rec_valid == 1'b0, "R1", "mid-run reset",
        {busy, done, rec_valid}, 0);
    rst_n = 1'b1;
    // the block resumes normal service after that reset
    run_camp(32'h0000_0001, 2, 8, 1'b0, 0, 1'b0);

    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      errs++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

endmodule